// File: doc/BRIEF.md
# Shared Dual Diffusion Matrix Unit

This block is the linear layer that follows the S-boxes in both round-function variants of a 128-bit Feistel block cipher. It takes a 32-bit word made of four S-box output bytes and multiplies it, as a vector over GF(2^8), by one of two fixed 4x4 diffusion matrices. A one-bit select picks the matrix on every cycle, so the same hardware serves either round function.

The two matrices are not built as two circuits. Each input byte is passed once through a chain of doubling (xtime) stages that yields its products by 02, 04 and 08. For every output byte, the select steers which of those shared products enter a small XOR tree. The products by 06 and 0A are formed as XORs of the 02, 04 and 08 products. The result is captured in an output register that loads only on a valid input. A valid flag travels alongside the data.

Both matrices are their own inverses. Applying the unit twice with the same select therefore returns the original word.

Top module: `dual_diffusion_unit`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `out_word` is 0.
- R2: With `mat_sel` = 0, output byte j equals the GF(2^8) sum over input bytes i of c0[i xor j]·x_i, where c0 = {01, 02, 04, 06} indexed by i xor j = 0..3. Byte 0 is bits [31:24] and byte 3 is bits [7:0].
- R3: With `mat_sel` = 1, output byte j equals the GF(2^8) sum over input bytes i of c1[i xor j]·x_i, where c1 = {01, 08, 02, 0A} indexed by i xor j = 0..3. The byte order is the same as in R2.
- R4: The result of an input accepted with `in_valid` = 1 appears on `out_word` one clock later. `out_valid` equals `in_valid` delayed by one clock.
- R5: When `in_valid` is 0, `out_word` keeps its value, whatever `in_word` and `mat_sel` do.
- R6: Field arithmetic uses the polynomial z^8+z^4+z^3+z^2+1. A doubling whose top bit shifts out XORs in 0x1D; for example, 02·0x80 = 0x1D.
- R7: Each matrix is an involution. Passing a word through the unit twice with the same `mat_sel` returns the original word.
- R8: `mat_sel` takes effect per accepted word. Back-to-back valid words with different selects each use their own matrix.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word is valid this cycle |
| mat_sel | input | 1 | Selects the matrix: 0 picks the first (01/02/04/06), 1 picks the second (01/08/02/0A) |
| in_word | input | 32 | Four S-box output bytes; byte 0 is bits [31:24] |
| out_valid | output | 1 | Registered result is fresh |
| out_word | output | 32 | Registered mixed word |

## Verification
The unit is first driven with words that have a single nonzero byte. These show each matrix column alone, so a misplaced coefficient or a swapped byte lane stands out. A top-bit byte such as 0x80 in one lane forces the reduction branch of every doubling stage. This separates a correct polynomial from a missing or wrong reduction.

Dense multi-byte words under both selects, each checked against an independent shift-and-add multiplier, catch errors in the shared XOR trees. Double application with the same select, and back-to-back words with alternating selects, show that the steering picks a consistent matrix per word.

// File: rtl/ddu_pkg.sv
package ddu_pkg;

  localparam int BYTE_W  = 8;
  localparam int LANES   = 4;
  localparam int WORD_W  = BYTE_W * LANES;
  localparam logic [BYTE_W-1:0] RED_POLY = 8'h1D;

  typedef struct packed {
    logic [BYTE_W-1:0] p8;
    logic [BYTE_W-1:0] p4;
    logic [BYTE_W-1:0] p2;
    logic [BYTE_W-1:0] p1;
  } prod_set_t;

  // one doubling step in GF(2^8)
  function automatic logic [BYTE_W-1:0] gf_dbl(input logic [BYTE_W-1:0] a);
    return {a[BYTE_W-2:0], 1'b0} ^ (a[BYTE_W-1] ? RED_POLY : '0);
  endfunction

endpackage

// File: rtl/ddu_prod_gen.sv
module ddu_prod_gen
  import ddu_pkg::*;
(
  input  logic [BYTE_W-1:0] x,
  output prod_set_t         prods
);
  logic [BYTE_W-1:0] d1, d2, d3;

  always_comb begin
    d1 = gf_dbl(x);
    d2 = gf_dbl(d1);
    d3 = gf_dbl(d2);
    prods.p1 = x;
    prods.p2 = d1;
    prods.p4 = d2;
    prods.p8 = d3;
  end
endmodule

// File: rtl/ddu_row_mix.sv
module ddu_row_mix
  import ddu_pkg::*;
(
  input  logic              sel,
  input  prod_set_t         own,
  input  prod_set_t         far1,
  input  prod_set_t         far2,
  input  prod_set_t         far3,
  output logic [BYTE_W-1:0] y
);
  logic [BYTE_W-1:0] t1, t2, t3;

  always_comb begin
    // lane distance 1: 02 or 08
    t1 = sel ? far1.p8 : far1.p2;
    // lane distance 2: 04 or 02
    t2 = sel ? far2.p2 : far2.p4;
    // lane distance 3: 06 or 0A, both share the 02 product
    t3 = far3.p2 ^ (sel ? far3.p8 : far3.p4);
    y  = own.p1 ^ t1 ^ t2 ^ t3;
  end
endmodule

// File: rtl/ddu_out_reg.sv
module ddu_out_reg
  import ddu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] d,
  output logic              q_valid,
  output logic [WORD_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q       <= '0;
      q_valid <= 1'b0;
    end else begin
      q_valid <= load;
      if (load) q <= d;
    end
  end
endmodule

// File: rtl/dual_diffusion_unit.sv
module dual_diffusion_unit
  import ddu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              mat_sel,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word
);
  prod_set_t         lane_prod [LANES];
  logic [WORD_W-1:0] mixed_word;
  logic              load_en;

  assign load_en = in_valid;

  for (genvar i = 0; i < LANES; i++) begin : g_prod
    ddu_prod_gen u_prod (
      .x     (in_word[WORD_W-1-BYTE_W*i -: BYTE_W]),
      .prods (lane_prod[i])
    );
  end

  for (genvar j = 0; j < LANES; j++) begin : g_row
    ddu_row_mix u_row (
      .sel  (mat_sel),
      .own  (lane_prod[j]),
      .far1 (lane_prod[j ^ 1]),
      .far2 (lane_prod[j ^ 2]),
      .far3 (lane_prod[j ^ 3]),
      .y    (mixed_word[WORD_W-1-BYTE_W*j -: BYTE_W])
    );
  end

  ddu_out_reg u_oreg (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load_en),
    .d       (mixed_word),
    .q_valid (out_valid),
    .q       (out_word)
  );
endmodule

// File: rtl/ddu_checker.sv
module ddu_checker
  import ddu_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              mat_sel,
  input logic [WORD_W-1:0] in_word,
  input logic              load_en,
  input logic              out_valid,
  input logic [WORD_W-1:0] out_word
);
  assert_valid_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> out_valid);

  assert_valid_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> !out_valid);

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_word));

  assert_zero_map_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_word == '0) |=> (out_word == '0));

  assert_lane0_col_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_word == 32'h0100_0000) |=>
      (out_word == ($past(mat_sel) ? 32'h0108_020A : 32'h0102_0406)));
endmodule

bind dual_diffusion_unit ddu_checker u_ddu_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .mat_sel   (mat_sel),
  .in_word   (in_word),
  .load_en   (load_en),
  .out_valid (out_valid),
  .out_word  (out_word)
);

// File: tb/tb_dual_diffusion_unit.sv
module tb_dual_diffusion_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        mat_sel = 1'b0;
  logic [31:0] in_word = '0;
  logic        out_valid;
  logic [31:0] out_word;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  dual_diffusion_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mat_sel(mat_sel),
    .in_word(in_word), .out_valid(out_valid), .out_word(out_word)
  );

  // word, select, expected
  localparam int NV = 8;
  localparam logic [64:0] VEC [NV] = '{
    {32'h8000_0000, 1'b0, 32'h801D_3A27},
    {32'h8000_0000, 1'b1, 32'h8074_1D69},
    {32'h0000_0001, 1'b0, 32'h0604_0201},
    {32'h0000_0001, 1'b1, 32'h0A02_0801},
    {32'h0001_0000, 1'b0, 32'h0201_0604},
    {32'h0001_0000, 1'b1, 32'h0801_0A02},
    {32'h0000_0100, 1'b0, 32'h0406_0102},
    {32'h0000_0000, 1'b1, 32'h0000_0000}
  };

  // shift-and-add multiply, polynomial 0x11D
  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r = '0;
    logic [7:0] aa = a;
    for (int k = 0; k < 8; k++) begin
      if (b[k]) r ^= aa;
      aa = aa[7] ? ((aa << 1) ^ 8'h1D) : (aa << 1);
    end
    return r;
  endfunction

  function automatic logic [31:0] model(input logic [31:0] w, input logic s);
    logic [7:0] c0 [4] = '{8'h01, 8'h02, 8'h04, 8'h06};
    logic [7:0] c1 [4] = '{8'h01, 8'h08, 8'h02, 8'h0A};
    logic [31:0] r = '0;
    for (int j = 0; j < 4; j++) begin
      logic [7:0] acc = '0;
      for (int i = 0; i < 4; i++) begin
        logic [7:0] xi = w[31-8*i -: 8];
        acc ^= gmul(xi, s ? c1[i ^ j] : c0[i ^ j]);
      end
      r[31-8*j -: 8] = acc;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%08h exp=%08h", req, got, exp);
    end
  endtask

  // drive one valid word, return the registered result
  task automatic apply(input logic [31:0] w, input logic s, output logic [31:0] y);
    @(negedge clk);
    in_valid = 1'b1; in_word = w; mat_sel = s;
    @(negedge clk);
    in_valid = 1'b0;
    y = out_word;
  endtask

  initial begin
    logic [31:0] y, y2, held;
    logic [31:0] pats [6] = '{32'h1234_5678, 32'hFFFF_FFFF, 32'hDEAD_BEEF,
                              32'h8080_8080, 32'h0F1E_2D3C, 32'hA5C3_7E19};
    #1;
    check("R1 reset valid", {31'd0, out_valid}, 32'd0);
    check("R1 reset word", out_word, 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      apply(VEC[v][64:33], VEC[v][32], y);
      check(VEC[v][32] ? "R3 R6 table" : "R2 R6 table", y, VEC[v][31:0]);
    end

    for (int p = 0; p < 6; p++) begin
      for (int s = 0; s < 2; s++) begin
        apply(pats[p], s[0], y);
        check(s ? "R3 model" : "R2 model", y, model(pats[p], s[0]));
        apply(y, s[0], y2);
        check("R7 involution", y2, pats[p]);
      end
    end

    // R4 latency and valid
    @(negedge clk);
    in_valid = 1'b1; in_word = 32'h1111_2222; mat_sel = 1'b0;
    check("R4 valid before edge", {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    check("R4 valid after edge", {31'd0, out_valid}, 32'd1);
    check("R4 data after edge", out_word, model(32'h1111_2222, 1'b0));
    // R8 back-to-back with alternating select
    in_word = 32'h3344_5566; mat_sel = 1'b1;
    @(negedge clk);
    check("R8 second word", out_word, model(32'h3344_5566, 1'b1));
    in_word = 32'h7788_99AA; mat_sel = 1'b0;
    @(negedge clk);
    check("R8 third word", out_word, model(32'h7788_99AA, 1'b0));
    in_valid = 1'b0;
    held = out_word;
    // R5 hold with toggling inputs
    for (int k = 0; k < 5; k++) begin
      in_word = 32'hC0DE_0000 + k; mat_sel = k[0];
      @(negedge clk);
      check("R5 hold word", out_word, held);
      check("R5 valid low", {31'd0, out_valid}, 32'd0);
    end

    // R1 reset mid-run
    rst_n = 1'b0;
    #1;
    check("R1 reset again", out_word, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog got=hung exp=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule